// File: doc/BRIEF.md
# Zero-Crossing Interval and Energy Extractor

This block sits behind one band-pass channel of a filter bank and turns its stream of signed samples into two features per signal period. A bang-bang offset tracker follows the slow DC level of the input and subtracts it, which leaves the AC part of the signal. Each time that AC part goes from negative to non-negative, the block closes the current period. It records how many samples the period lasted and the sum of the rectified AC magnitude over those samples.

When a period closes, both features are copied into holding registers and a service request goes high. The request stays high until a downstream consumer pulses the clear input. If another period closes before that clear arrives, the held values are replaced and an overrun flag is set. The time constant of the tracker is chosen per channel with a rate divider input. Each channel of a bank gets its own instance.

Top module: `zc_feature_extractor`

## Requirements
- R1: During and right after reset, reqOut and overrunOut are 0 and intervalOut and energyOut are 0.
- R2: The offset estimate starts at 0. It is updated once every rateDiv+1 valid samples. An update moves it one step toward the current sample: up by 1 if the sample is larger, down by 1 if smaller, unchanged if equal. The corrected sample is sampleIn minus the estimate held before the update.
- R3: An upward crossing is a valid sample whose corrected value is non-negative when the previous valid sample's corrected value was negative. The first valid sample after reset cannot be a crossing.
- R4: The interval captured at a crossing is the number of valid samples after the previous crossing, up to and including the current one. It saturates at 2^INTERVAL_W-1.
- R5: The energy captured at a crossing is the sum of the absolute corrected values over the same samples. It saturates at 2^ENERGY_W-1.
- R6: The first crossing after reset only starts a period. It captures nothing and leaves reqOut low.
- R7: Every later crossing updates intervalOut and energyOut and sets reqOut, all visible one clock after the crossing sample.
- R8: reqOut stays high until clearReq is sampled high. A clear in the same cycle as a capture leaves reqOut high.
- R9: A capture while reqOut is high and clearReq is low sets overrunOut. clearReq clears overrunOut.
- R10: A cycle with sampleValid low changes neither the tracker, the period counters, nor the crossing history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | A new sample is present this cycle |
| sampleIn | input | SAMPLE_W | Signed channel sample |
| rateDiv | input | RATE_W | Tracker update every rateDiv+1 valid samples |
| clearReq | input | 1 | Clears the request and overrun flags |
| reqOut | output | 1 | Held features are waiting to be read |
| overrunOut | output | 1 | A held result was overwritten before being cleared |
| intervalOut | output | INTERVAL_W | Held period length in samples |
| energyOut | output | ENERGY_W | Held rectified energy of that period |

## Verification
The bench uses SAMPLE_W=8, INTERVAL_W=6 and ENERGY_W=10. With these widths, one 160-sample period of amplitude 100 drives both the interval counter and the energy sum into saturation. RATE_W=4 allows both rateDiv=0, where the tracker settles onto a DC step within tens of samples, and rateDiv=15, where it barely moves during a long period. The clear input is pulsed on a fixed cadence that is not tied to the signal period, so clears land before, on and after crossings.

// File: rtl/zcfe_pkg.sv
package zcfe_pkg;
  typedef struct packed {
    logic restart;   // close the running period
    logic capture;   // copy the period's features into the holding registers
  } zcfe_strobe_t;
endpackage

// File: rtl/zcfe_datapath.sv
module zcfe_datapath
  import zcfe_pkg::*;
#(
  parameter int SAMPLE_W   = 12,
  parameter int INTERVAL_W = 16,
  parameter int ENERGY_W   = 24,
  parameter int RATE_W     = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sampleValid,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic [RATE_W-1:0]          rateDiv,
  input  zcfe_strobe_t               strb,
  output logic                       acNeg,
  output logic [INTERVAL_W-1:0]      intervalOut,
  output logic [ENERGY_W-1:0]        energyOut
);
  localparam int AC_W = SAMPLE_W + 1;
  localparam logic [INTERVAL_W-1:0] INT_MAX = '1;
  localparam logic [ENERGY_W-1:0]   EN_MAX  = '1;

  logic signed [SAMPLE_W-1:0] offsetQ;
  logic [RATE_W-1:0]          divCntQ;
  logic [INTERVAL_W-1:0]      cntQ, cntNext;
  logic [ENERGY_W-1:0]        energyQ, energyNext;
  logic [INTERVAL_W-1:0]      heldIntQ;
  logic [ENERGY_W-1:0]        heldEnQ;
  logic signed [AC_W-1:0]     acVal;
  logic [AC_W-1:0]            acMag;
  logic [INTERVAL_W:0]        cntSum;
  logic [ENERGY_W:0]          enSum;

  // offset-corrected sample and its magnitude
  always_comb begin
    acVal = AC_W'(sampleIn) - AC_W'(offsetQ);
    acNeg = acVal[AC_W-1];
    acMag = acNeg ? AC_W'(-acVal) : AC_W'(acVal);
  end

  // saturating increments of the running period
  always_comb begin
    cntSum     = {1'b0, cntQ} + (INTERVAL_W+1)'(1);
    cntNext    = cntSum[INTERVAL_W] ? INT_MAX : cntSum[INTERVAL_W-1:0];
    enSum      = {1'b0, energyQ} + (ENERGY_W+1)'(acMag);
    energyNext = enSum[ENERGY_W] ? EN_MAX : enSum[ENERGY_W-1:0];
  end

  // bang-bang offset tracker with rate divider
  always_ff @(posedge clk) begin
    if (!rstN) begin
      offsetQ <= '0;
      divCntQ <= '0;
    end else if (sampleValid) begin
      if (divCntQ >= rateDiv) begin
        divCntQ <= '0;
        if (sampleIn > offsetQ)      offsetQ <= offsetQ + 1'b1;
        else if (sampleIn < offsetQ) offsetQ <= offsetQ - 1'b1;
      end else begin
        divCntQ <= divCntQ + 1'b1;
      end
    end
  end

  // period counters and holding registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ     <= '0;
      energyQ  <= '0;
      heldIntQ <= '0;
      heldEnQ  <= '0;
    end else if (sampleValid) begin
      if (strb.restart) begin
        cntQ    <= '0;
        energyQ <= '0;
      end else begin
        cntQ    <= cntNext;
        energyQ <= energyNext;
      end
      if (strb.capture) begin
        heldIntQ <= cntNext;
        heldEnQ  <= energyNext;
      end
    end
  end

  assign intervalOut = heldIntQ;
  assign energyOut   = heldEnQ;

  // R2
  offset_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (offsetQ == $past(offsetQ)) || (offsetQ == $past(offsetQ) + 1'b1) ||
    (offsetQ == $past(offsetQ) - 1'b1));
  // R10
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(offsetQ) && $stable(cntQ) && $stable(energyQ) && $stable(heldIntQ));
  // R4
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid && !strb.restart && cntQ == INT_MAX |=> cntQ == INT_MAX);
  // R5
  en_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid && !strb.restart && energyQ == EN_MAX |=> energyQ == EN_MAX);
endmodule

// File: rtl/zcfe_control.sv
module zcfe_control
  import zcfe_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         sampleValid,
  input  logic         acNeg,
  input  logic         clearReq,
  output zcfe_strobe_t strb,
  output logic         reqOut,
  output logic         overrunOut
);
  logic prevNegQ, armedQ, reqQ, overrunQ;
  logic upCross;

  always_comb begin
    upCross      = sampleValid && prevNegQ && !acNeg;
    strb.restart = upCross;
    strb.capture = upCross && armedQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevNegQ <= 1'b0;
      armedQ   <= 1'b0;
      reqQ     <= 1'b0;
      overrunQ <= 1'b0;
    end else begin
      if (sampleValid) prevNegQ <= acNeg;
      if (upCross)     armedQ   <= 1'b1;
      if (strb.capture)  reqQ <= 1'b1;
      else if (clearReq) reqQ <= 1'b0;
      if (strb.capture && reqQ && !clearReq) overrunQ <= 1'b1;
      else if (clearReq)                     overrunQ <= 1'b0;
    end
  end

  assign reqOut     = reqQ;
  assign overrunOut = overrunQ;

  // R6
  first_cross_chk: assert property (@(posedge clk) disable iff (!rstN)
    upCross && !armedQ |=> !reqQ);
  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqQ && !clearReq |=> reqQ);
  // R7
  req_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> reqQ);
  // R9
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture && reqQ && !clearReq |=> overrunQ);
  // R9
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunQ) |-> $past(reqQ));
endmodule

// File: rtl/zc_feature_extractor.sv
module zc_feature_extractor
  import zcfe_pkg::*;
#(
  parameter int SAMPLE_W   = 12,
  parameter int INTERVAL_W = 16,
  parameter int ENERGY_W   = 24,
  parameter int RATE_W     = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sampleValid,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic [RATE_W-1:0]          rateDiv,
  input  logic                       clearReq,
  output logic                       reqOut,
  output logic                       overrunOut,
  output logic [INTERVAL_W-1:0]      intervalOut,
  output logic [ENERGY_W-1:0]        energyOut
);
  zcfe_strobe_t strb;
  logic         acNeg;

  zcfe_datapath #(
    .SAMPLE_W(SAMPLE_W), .INTERVAL_W(INTERVAL_W),
    .ENERGY_W(ENERGY_W), .RATE_W(RATE_W)
  ) dp (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .rateDiv(rateDiv), .strb(strb), .acNeg(acNeg),
    .intervalOut(intervalOut), .energyOut(energyOut)
  );

  zcfe_control ctl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .acNeg(acNeg),
    .clearReq(clearReq), .strb(strb), .reqOut(reqOut), .overrunOut(overrunOut)
  );
endmodule

// File: tb/zc_feature_extractor_test.sv
module zc_feature_extractor_test;
  localparam int SW = 8, IW = 6, EW = 10, RW = 4;
  localparam int IMAX = (1 << IW) - 1;
  localparam int EMAX = (1 << EW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic signed [SW-1:0] sampleIn = '0;
  logic [RW-1:0] rateDiv = '0;
  logic clearReq = 1'b0;
  logic reqOut, overrunOut;
  logic [IW-1:0] intervalOut;
  logic [EW-1:0] energyOut;

  int errors = 0, checks = 0, cycles = 0;
  bit running = 1'b1;

  // reference model state
  int mOff, mDiv, mCnt, mEn, mHInt, mHEn;
  bit mPrevNeg, mArmed, mReq, mOvr;

  always #4 clk = ~clk;

  zc_feature_extractor #(.SAMPLE_W(SW), .INTERVAL_W(IW), .ENERGY_W(EW), .RATE_W(RW)) uut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .rateDiv(rateDiv), .clearReq(clearReq), .reqOut(reqOut), .overrunOut(overrunOut),
    .intervalOut(intervalOut), .energyOut(energyOut)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mOff = 0; mDiv = 0; mCnt = 0; mEn = 0; mHInt = 0; mHEn = 0;
      mPrevNeg = 0; mArmed = 0; mReq = 0; mOvr = 0;
    end else begin
      int s, ac, mag, cIn, eIn;
      bit neg, up, cap, nReq, nOvr;
      s   = int'(sampleIn);
      ac  = s - mOff;
      neg = ac < 0;
      mag = neg ? -ac : ac;
      up  = sampleValid && mPrevNeg && !neg;
      cap = up && mArmed;
      nReq = cap ? 1'b1 : (clearReq ? 1'b0 : mReq);
      nOvr = (cap && mReq && !clearReq) ? 1'b1 : (clearReq ? 1'b0 : mOvr);
      if (sampleValid) begin
        cIn = (mCnt + 1 > IMAX) ? IMAX : mCnt + 1;
        eIn = (mEn + mag > EMAX) ? EMAX : mEn + mag;
        if (cap) begin mHInt = cIn; mHEn = eIn; end
        if (up) begin mCnt = 0; mEn = 0; mArmed = 1; end
        else begin mCnt = cIn; mEn = eIn; end
        mPrevNeg = neg;
        if (mDiv >= int'(rateDiv)) begin
          mDiv = 0;
          if (s > mOff) mOff++;
          else if (s < mOff) mOff--;
        end else mDiv++;
      end
      mReq = nReq; mOvr = nOvr;
    end
  end

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (rstN && running) begin
      check("R3 R6 R7 R8 R10 reqOut", int'(reqOut), int'(mReq));
      check("R9 overrunOut", int'(overrunOut), int'(mOvr));
      check("R2 R3 R4 R7 intervalOut", int'(intervalOut), mHInt);
      check("R2 R5 R7 energyOut", int'(energyOut), mHEn);
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (running) begin
      running = 1'b0;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic drive(input int s, input bit v, input bit c);
    @(negedge clk);
    sampleIn = SW'(s); sampleValid = v; clearReq = c;
  endtask

  task automatic square(input int hi, input int lo, input int amp, input int base,
                        input int reps, input int clrEvery);
    int n = 0;
    for (int r = 0; r < reps; r++) begin
      for (int i = 0; i < lo; i++) begin n++; drive(base - amp, 1, clrEvery > 0 && n % clrEvery == 0); end
      for (int i = 0; i < hi; i++) begin n++; drive(base + amp, 1, clrEvery > 0 && n % clrEvery == 0); end
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 reqOut", int'(reqOut), 0);
    check("R1 overrunOut", int'(overrunOut), 0);
    check("R1 intervalOut", int'(intervalOut), 0);
    check("R1 energyOut", int'(energyOut), 0);
    rstN = 1'b1;
    rateDiv = 0;
    // R6: first crossing raises no request
    for (int i = 0; i < 5; i++) drive(-20, 1, 0);
    drive(20, 1, 0);
    drive(20, 0, 0);
    check("R6 reqOut after first crossing", int'(reqOut), 0);
    // R7 R9: periods without clear lead to overrun
    square(5, 5, 20, 0, 4, 0);
    drive(0, 0, 0);
    check("R9 overrunOut after unserviced periods", int'(overrunOut), 1);
    // R8: clear drops the flags
    drive(0, 0, 1);
    drive(0, 0, 0);
    check("R8 reqOut after clear", int'(reqOut), 0);
    check("R9 overrunOut after clear", int'(overrunOut), 0);
    // R2: DC step then a small wave around it, slower tracker
    for (int i = 0; i < 80; i++) drive(60, 1, 0);
    rateDiv = 3;
    square(4, 4, 10, 60, 6, 3);
    // R10: gaps in sampleValid
    for (int i = 0; i < 40; i++) drive((i % 6 < 3) ? -30 : 30, (i % 3) != 0, i % 11 == 0);
    for (int i = 0; i < 6; i++) drive(i * 37 - 100, 0, 0);
    // R4 R5: long periods saturate both features
    rateDiv = 15;
    square(80, 80, 100, 0, 3, 0);
    // R8 R9: clears at a cadence unrelated to the period
    rateDiv = 1;
    square(3, 4, 50, 0, 20, 5);
    square(2, 2, 7, -3, 20, 4);
    repeat (3) drive(0, 0, 0);
    running = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule